// File: doc/BRIEF.md
# Shadow-RAM Store/Recall Controller

The block models a small nonvolatile static RAM: a working array of words that the host reads and writes directly, and a second shadow array of the same size that keeps a bit-for-bit copy across power loss. An active-low store pulse copies the whole working array into the shadow array. An active-low recall pulse copies the shadow array back into the working array. Each trigger must stay low for a set number of clock cycles before the copy starts. After that the copy occupies the block for a fixed number of cycles, whatever the trigger pin does.

Ordinary reads and writes use an active-low chip select and an active-low write enable. They run only while both triggers are high and no copy is in progress. The read word comes out with its own output-enable, so the data port can be tri-stated outside the block. A power-good input stands in for supply sensing and blocks a store while the supply is low. Recall wins over store. A busy flag and a two-bit operation code show which copy is running.

Top module: `nvsram_ctrl`

## Requirements
- R1: After reset both arrays hold zero in every word, busy is 0 and the operation code is 00 (idle).
- R2: With chip select high the output-enable is 0 and no write takes place, whatever write enable does.
- R3: With chip select low, both triggers high and busy 0, write enable low stores the data word at the address on the next rising edge. Write enable high drives output-enable to 1 and presents the addressed word on the data output in the same cycle. A write attempted while a trigger is low is dropped.
- R4: A store starts at the rising edge on which the store input has been sampled low for STORE_PW consecutive edges, provided recall is high, power-good is high and the block is idle. At that edge the shadow array takes the working array. Busy is then 1 with operation code 01 for exactly STORE_CYC cycles. A shorter pulse has no effect, and one low pulse starts at most one store.
- R5: A recall starts at the rising edge on which the recall input has been sampled low for RECALL_PW consecutive edges while the block is idle. At that edge the working array takes the shadow array. Busy is then 1 with operation code 10 for exactly RECALL_CYC cycles.
- R6: While busy, the store and recall pins, chip select, write enable and address have no effect: no write lands, no second copy starts and the operation code stays unchanged.
- R7: Output-enable is 0 while busy and while either trigger input is low. This includes a recall input held low after its copy has ended.
- R8: A store whose pulse qualifies while power-good is 0 is dropped, and the shadow array keeps its contents.
- R9: While recall is low no store starts. When both triggers go low together, the recall runs and the store is discarded.
- R10: If a store starts while chip select and write enable are both low, the store still runs. The addressed word becomes undefined in both arrays, and every other word is copied normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| store_n | input | 1 | Store trigger, active low |
| recall_n | input | 1 | Recall trigger, active low |
| pwr_ok | input | 1 | Supply-good indication, 1 = supply adequate |
| addr | input | ADDR_W (6) | Word address |
| din | input | DATA_W (4) | Write data |
| dout | output | DATA_W (4) | Addressed word of the working array |
| dout_oe | output | 1 | Data output enable, 0 = high impedance |
| busy | output | 1 | A whole-array copy is in progress |
| op_kind | output | 2 | 00 idle, 01 store, 10 recall |

## Verification
The bench probes the pulse-width boundary one cycle short of the minimum and exactly at it. A qualifier that is off by one would start copies early, or fail to start them at all. It also measures the busy window to the cycle, so a timer that is off by one shows up as a window one cycle too long or too short. During each copy the bench drives a write and a full-width pulse on the opposite trigger. A design that leaks either one corrupts a word, switches the operation code or starts a second copy. The store is also tried with power-good low and together with recall. Each of these cases ends with a recall round trip and a full sweep of every address, so a store that should have been blocked but wrote the shadow array shows up as changed words.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'b00,
    OP_STORE  = 2'b01,
    OP_RECALL = 2'b10
  } op_e;

  // Width of a counter that must reach the value n.
  function automatic int unsigned count_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Number of busy cycles of a given operation.
  function automatic int unsigned op_cycles(input op_e op, input int unsigned st_cyc,
                                            input int unsigned rc_cyc);
    return (op == OP_STORE) ? st_cyc : (op == OP_RECALL) ? rc_cyc : 0;
  endfunction

endpackage

// File: rtl/nvs_pulse_qual.sv
module nvs_pulse_qual #(
  parameter int unsigned PW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_n,
  output logic fire
);
  import nvs_pkg::*;

  localparam int unsigned CW = count_width(PW);

  logic [CW-1:0] low_cnt;

  // Saturating count of consecutive low samples; passes PW-1 once per pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (trig_n) begin
      low_cnt <= '0;
    end else if (low_cnt != CW'(PW)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign fire = !trig_n && (low_cnt == CW'(PW - 1));

  // A qualified pulse was low on the previous sample as well.
  assert_fire_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (PW > 1)) |-> !$past(trig_n));

endmodule

// File: rtl/nvs_sequencer.sv
module nvs_sequencer #(
  parameter int unsigned STORE_CYC  = 200,
  parameter int unsigned RECALL_CYC = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          store_fire,
  input  logic          recall_fire,
  input  logic          recall_n,
  input  logic          pwr_ok,
  output logic          store_go,
  output logic          recall_go,
  output logic          busy,
  output nvs_pkg::op_e  op
);
  import nvs_pkg::*;

  localparam int unsigned TW = count_width(max_u(STORE_CYC, RECALL_CYC));

  logic [TW-1:0] timer;
  logic [TW-1:0] run_len;
  logic          run_end;

  // Recall has priority; store also needs power-good and an inactive recall.
  assign recall_go = recall_fire && !busy;
  assign store_go  = store_fire && !busy && recall_n && pwr_ok;
  assign run_end   = busy && (timer == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      op    <= OP_IDLE;
      timer <= '0;
    end else if (recall_go) begin
      busy  <= 1'b1;
      op    <= OP_RECALL;
      timer <= TW'(RECALL_CYC - 1);
    end else if (store_go) begin
      busy  <= 1'b1;
      op    <= OP_STORE;
      timer <= TW'(STORE_CYC - 1);
    end else if (run_end) begin
      busy  <= 1'b0;
      op    <= OP_IDLE;
    end else if (busy) begin
      timer <= timer - 1'b1;
    end
  end

  // Independent length counter for the duration check.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      run_len <= '0;
    else if (recall_go || store_go)  run_len <= '0;
    else if (busy)                   run_len <= run_len + 1'b1;
  end

  assert_hold_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (timer != '0)) |=> (busy && (op == $past(op))));

  assert_store_pwr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && (op == OP_STORE)) |-> $past(pwr_ok));

  assert_recall_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && (op == OP_STORE)) |-> $past(recall_n));

  assert_duration_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(run_len) == TW'(op_cycles($past(op), STORE_CYC, RECALL_CYC) - 1)));

endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_store,
  input  logic              do_recall,
  input  logic              wr_en,
  input  logic              poison,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] work_q   [DEPTH];
  logic [DATA_W-1:0] shadow_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        work_q[i]   <= '0;
        shadow_q[i] <= '0;
      end
    end else begin
      if (do_store) begin
        for (int i = 0; i < DEPTH; i++) shadow_q[i] <= work_q[i];
      end
      if (do_recall) begin
        for (int i = 0; i < DEPTH; i++) work_q[i] <= shadow_q[i];
      end
      if (wr_en) work_q[addr] <= wr_data;
      if (poison) begin
        work_q[addr]   <= {DATA_W{1'bx}};
        shadow_q[addr] <= {DATA_W{1'bx}};
      end
    end
  end

  assign rd_data = work_q[addr];

  assert_one_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_store && do_recall));

  assert_no_write_in_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (do_store || do_recall)));

endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl #(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned DATA_W     = 4,
  parameter int unsigned STORE_PW   = 4,
  parameter int unsigned RECALL_PW  = 3,
  parameter int unsigned STORE_CYC  = 200,
  parameter int unsigned RECALL_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              store_n,
  input  logic              recall_n,
  input  logic              pwr_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              busy,
  output logic [1:0]        op_kind
);
  import nvs_pkg::*;

  logic store_fire, recall_fire;
  logic store_go, recall_go;
  logic nv_quiet;
  logic wr_en, poison;
  op_e  op;

  nvs_pulse_qual #(.PW(STORE_PW)) u_store_q (
    .clk(clk), .rst_n(rst_n), .trig_n(store_n), .fire(store_fire)
  );

  nvs_pulse_qual #(.PW(RECALL_PW)) u_recall_q (
    .clk(clk), .rst_n(rst_n), .trig_n(recall_n), .fire(recall_fire)
  );

  nvs_sequencer #(.STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .store_fire(store_fire), .recall_fire(recall_fire),
    .recall_n(recall_n), .pwr_ok(pwr_ok),
    .store_go(store_go), .recall_go(recall_go),
    .busy(busy), .op(op)
  );

  // Normal access only when no trigger is low and no copy runs.
  assign nv_quiet = store_n && recall_n && !busy;
  assign wr_en    = !cs_n && !we_n && nv_quiet;
  assign dout_oe  = !cs_n &&  we_n && nv_quiet;
  assign poison   = store_go && !cs_n && !we_n;

  nvs_arrays #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .do_store(store_go), .do_recall(recall_go),
    .wr_en(wr_en), .poison(poison),
    .addr(addr), .wr_data(din), .rd_data(dout)
  );

  assign op_kind = op;

  assert_oe_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dout_oe);

  assert_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !dout_oe);

endmodule

// File: tb/nvsram_ctrl_tb_top.sv
`timescale 1ns/1ps
module nvsram_ctrl_tb_top;
  localparam int SPW = 4, RPW = 3, SCYC = 200, RCYC = 20;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, we_n = 1, store_n = 1, recall_n = 1, pwr_ok = 1;
  logic [5:0] addr = 0;
  logic [3:0] din = 0;
  logic [3:0] dout;
  logic dout_oe, busy;
  logic [1:0] op_kind;

  int n_checks = 0, n_err = 0;
  bit done = 0;
  logic [3:0] m_ram [64];
  logic [3:0] m_sh  [64];
  bit skip [64];

  always #2 clk = ~clk;

  nvsram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .store_n(store_n),
    .recall_n(recall_n), .pwr_ok(pwr_ok), .addr(addr), .din(din),
    .dout(dout), .dout_oe(dout_oe), .busy(busy), .op_kind(op_kind)
  );

  function automatic logic [3:0] pat_a(input int a); return 4'((a * 5 + 3) & 15); endfunction
  function automatic logic [3:0] pat_b(input int a); return 4'((a * 11 + 6) & 15); endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wr(input int a, input logic [3:0] d);
    @(negedge clk); cs_n = 0; we_n = 0; addr = 6'(a); din = d;
    @(negedge clk); we_n = 1;
    m_ram[a] = d;
  endtask

  task automatic rd_all(input string tag);
    for (int a = 0; a < 64; a++) begin
      if (!skip[a]) begin
        @(negedge clk); cs_n = 0; we_n = 1; addr = 6'(a); #1;
        chk(dout_oe === 1'b1 && dout === m_ram[a], tag, int'(dout), int'(m_ram[a]));
      end
    end
  endtask

  task automatic fill(input bit use_b);
    for (int a = 0; a < 64; a++) wr(a, use_b ? pat_b(a) : pat_a(a));
  endtask

  task automatic run_op(input bit rec, input int hold, input bit exp_go,
                        input bit disturb, input bit wr_start, input string tag);
    int pw, dur;
    logic [1:0] code;
    pw = rec ? RPW : SPW;
    dur = rec ? RCYC : SCYC;
    code = rec ? 2'b10 : 2'b01;
    @(negedge clk); cs_n = 0; we_n = 1; addr = 0;
    if (rec) recall_n = 0; else store_n = 0;
    for (int i = 1; i <= pw + dur + 1; i++) begin
      @(negedge clk);
      if (i == pw - 1) chk(busy == 0, {tag, " not yet started"}, int'(busy), 0);
      if (i == pw) begin
        chk(busy == exp_go, {tag, " start edge busy"}, int'(busy), int'(exp_go));
        chk(op_kind == (exp_go ? code : 2'b00), {tag, " op code"}, int'(op_kind),
            int'(exp_go ? code : 2'b00));
      end
      if (exp_go && i == pw + 2) chk(dout_oe == 0, {tag, " R7 oe off while busy"}, int'(dout_oe), 0);
      if (disturb && i == pw + 8)
        chk(op_kind == code && busy, {tag, " R6 op held"}, int'(op_kind), int'(code));
      if (exp_go && i == pw + dur - 1) chk(busy == 1, {tag, " last busy cycle"}, int'(busy), 1);
      if (i == pw + dur) chk(busy == 0 && op_kind == 0, {tag, " idle after run"}, int'(busy), 0);
      if (i == pw + dur + 1) chk(dout_oe == 1, {tag, " R3 oe back"}, int'(dout_oe), 1);
      // stimulus after checks
      if (wr_start && i == pw - 1) begin we_n = 0; addr = 7; din = 4'h9; end
      if (wr_start && i == pw) we_n = 1;
      if (disturb && i == pw + 1) begin
        if (rec) store_n = 0; else recall_n = 0;
      end
      if (disturb && i == pw + 3) begin we_n = 0; addr = 5; din = m_ram[5] ^ 4'hF; end
      if (disturb && i == pw + 4) begin we_n = 1; addr = 0; end
      if (disturb && i == pw + 8) begin
        if (rec) store_n = 1; else recall_n = 1;
      end
      if (i == hold) begin
        if (rec) recall_n = 1; else store_n = 1;
      end
    end
    if (exp_go) begin
      for (int a = 0; a < 64; a++) begin
        if (rec) m_ram[a] = m_sh[a]; else m_sh[a] = m_ram[a];
      end
      if (wr_start) skip[7] = 1;
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 64; a++) begin m_ram[a] = 0; m_sh[a] = 0; skip[a] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && op_kind == 0, "R1 reset idle", int'(op_kind), 0);

    // R2: standby blocks output and writes
    @(negedge clk); cs_n = 1; we_n = 0; addr = 0; din = 4'h5; #1;
    chk(dout_oe == 0, "R2 standby oe", int'(dout_oe), 0);
    @(negedge clk); we_n = 1; #1;
    chk(dout_oe == 0, "R2 standby read oe", int'(dout_oe), 0);
    rd_all("R1/R2 zero sweep");

    // R3: write/read sweep
    fill(0);
    rd_all("R3 pattern A sweep");

    // R3: write with store low is dropped; 1-cycle store pulse does nothing
    @(negedge clk); store_n = 0; cs_n = 0; we_n = 0; addr = 1; din = ~pat_a(1); #1;
    chk(dout_oe == 0, "R7 oe off with store low", int'(dout_oe), 0);
    @(negedge clk); store_n = 1; we_n = 1;
    chk(busy == 0, "R4 one-cycle pulse", int'(busy), 0);
    @(negedge clk); addr = 1; #1;
    chk(dout == pat_a(1), "R3 write during store low dropped", int'(dout), int'(pat_a(1)));

    // R4: one cycle short of minimum width
    run_op(0, SPW - 1, 0, 0, 0, "R4 short store");
    // R4 + R6: full store with write and recall attempts inside
    run_op(0, SPW + 2, 1, 1, 0, "R4 store");
    rd_all("R6 RAM intact after store");

    // R5: recall restores pattern A
    fill(1);
    run_op(1, RPW, 1, 1, 0, "R5 recall");
    rd_all("R5 recalled sweep");

    // R8: store blocked by low supply
    fill(1);
    pwr_ok = 0;
    run_op(0, SPW + 1, 0, 0, 0, "R8 low supply store");
    pwr_ok = 1;
    run_op(1, RPW + 1, 1, 0, 0, "R8 recall after");
    rd_all("R8 shadow unchanged");

    // R9 + R7: both triggers together, recall held past completion
    fill(1);
    @(negedge clk); cs_n = 0; we_n = 1; store_n = 0; recall_n = 0;
    for (int i = 1; i <= RPW + RCYC + 3; i++) begin
      @(negedge clk);
      if (i == RPW) chk(busy && op_kind == 2'b10, "R9 recall wins", int'(op_kind), 2);
      if (i == RPW + RCYC) chk(busy == 0, "R9 recall done", int'(busy), 0);
      if (i == RPW + RCYC + 2) chk(dout_oe == 0 && busy == 0, "R7 oe off recall held", int'(dout_oe), 0);
      if (i == SPW + 1) store_n = 1;
    end
    recall_n = 1; #1;
    chk(dout_oe == 1, "R7 oe after recall release", int'(dout_oe), 1);
    for (int a = 0; a < 64; a++) m_ram[a] = m_sh[a];
    @(negedge clk);
    chk(busy == 0, "R5 no retrigger", int'(busy), 0);
    rd_all("R9 store discarded sweep");

    // R10: store at exact width while a write is requested
    fill(1);
    run_op(0, SPW, 1, 0, 1, "R10 store during write");
    fill(0);
    run_op(1, RPW, 1, 0, 0, "R10 recall back");
    rd_all("R10 other words copied");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule